// File: doc/BRIEF.md
# Flyback Fault Supervisor with Auto-Restart

This block is the supervisory state machine of an offline flyback controller. It takes digitized codes for the supply voltage, the feedback voltage, the die temperature and the current-sense voltage. It also takes the gate-on level and a measured on-time count, which is reported when each pulse ends. From these it drives three control outputs: an enable for the high-voltage startup source, an enable for switching, and a pulse-by-pulse current-limit cutoff. It also reports a fault-latched flag and the code of the fault that stopped switching.

The machine has three states: charging, running and faulted. A fault stays latched while the supply remains at or above the stop level, so a timer never clears it. Only a supply discharge below the stop level clears the fault. After that the supply must recharge to the start level before switching resumes. All thresholds are parameter codes, so the same block serves any converter's scaling.

Top module: `psu_fault_supervisor`

## Requirements
- R1: Reset puts the block in the charging state: startup_en=1, switch_en=0, fault_latched=0, fault_code=0.
- R2: While charging, a supply code at or above VCC_START moves the block to running on the next clock edge (startup_en=0, switch_en=1). A code one below VCC_START keeps it charging.
- R3: While running with no fault, a supply code below VCC_STOP returns the block to charging on the next edge. Codes between the two levels keep the current state.
- R4: A latched fault holds startup_en=0 and switch_en=0 for as long as the supply code stays at or above VCC_STOP. The first edge with the supply below VCC_STOP clears the fault and fault_code and returns the block to charging. Switching restarts only at VCC_START.
- R5: Overvoltage: while running, a supply code above VCC_OVP latches fault code 2 on the next edge.
- R6: Overload: while running, a feedback code above FB_OLP on OLP_DLY consecutive edges latches fault code 5 on the last of those edges. Any edge at or below FB_OLP restarts the count.
- R7: Output short: a short-pulse flag is taken at each on-time report (ton_valid) as ton_count < TON_SHORT and is cleared outside running. With the flag set and a feedback code above FB_OSP on OSP_DLY consecutive edges, fault code 3 latches.
- R8: Abnormal overcurrent: while running, gate_on=1 with a sense code above SNS_AOCP latches fault code 1 on the next edge. This includes edges inside the blanking window.
- R9: Thermal: a hot flag sets on an edge where the temperature code is at or above TEMP_HOT. It clears only on an edge where the code is at or below TEMP_COOL. While the flag is set, a running block latches fault code 4 on the next edge.
- R10: cl_off is 1 when the block is running, gate_on=1 and the sense code is above SNS_ILIM. It is held at 0 during the first LEB_CYC cycles of each gate-on pulse.
- R11: When several faults are present on the same edge, the lowest code is recorded (1 before 2, 3, 4, 5). fault_code holds unchanged while the fault stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_code | input | CODE_W | Digitized supply voltage |
| fb_code | input | CODE_W | Digitized feedback voltage |
| temp_code | input | CODE_W | Digitized die temperature |
| sense_code | input | CODE_W | Digitized current-sense voltage |
| gate_on | input | 1 | Power switch gate is on |
| ton_count | input | TON_W | Measured on-time of the pulse that just ended |
| ton_valid | input | 1 | ton_count is valid this cycle |
| startup_en | output | 1 | Enable for the high-voltage startup source |
| switch_en | output | 1 | Switching allowed |
| cl_off | output | 1 | Pulse-by-pulse current-limit cutoff |
| fault_latched | output | 1 | A protection fault is latched |
| fault_code | output | 3 | Recorded fault (0 none, 1 overcurrent, 2 overvoltage, 3 short, 4 thermal, 5 overload) |

## Verification
Two pairs of functions can act on the same edge. The first pair is the undervoltage exit from running and a fault trip. The bench provokes it by dropping the supply code below the stop level in the same cycle as an overcurrent. The expected result is that the fault is latched first, and one cycle later the still-low supply clears it into charging. The second pair is two fault detectors firing together: an overvoltage and an overcurrent are applied in the same cycle, and only the lower code must be recorded and then held unchanged.

// File: rtl/psu_sup_pkg.sv
package psu_sup_pkg;

  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_RUN    = 2'd1,
    ST_FAULT  = 2'd2
  } sup_state_e;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_AOCP = 3'd1,
    FC_OVP  = 3'd2,
    FC_OSP  = 3'd3,
    FC_TSD  = 3'd4,
    FC_OLP  = 3'd5
  } fault_code_e;

  // Fixed priority: the lowest code wins when detectors fire together.
  function automatic fault_code_e pick_first(input logic aocp, input logic ovp,
                                             input logic osp, input logic tsd,
                                             input logic olp);
    if (aocp)     return FC_AOCP;
    else if (ovp) return FC_OVP;
    else if (osp) return FC_OSP;
    else if (tsd) return FC_TSD;
    else if (olp) return FC_OLP;
    else          return FC_NONE;
  endfunction

  // Width of a counter that must reach the value n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sup_persist_timer.sv
module sup_persist_timer #(
  parameter int unsigned LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cond,
  output logic fire
);
  localparam int unsigned CW = psu_sup_pkg::cnt_bits(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          live;

  assign live = arm && cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!live)          cnt_q <= '0;
    else if (cnt_q != TOP)   cnt_q <= cnt_q + 1'b1;
  end

  assign fire = live && (cnt_q == LAST);

  generate
    if (LIMIT > 1) begin : g_hist
      AST_FIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(live)); // R6
    end
  endgenerate

endmodule

// File: rtl/sup_thermal_hyst.sv
module sup_thermal_hyst #(
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned TEMP_HOT  = 137,
  parameter int unsigned TEMP_COOL = 77
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] temp_code,
  output logic              hot
);
  logic set_hot, clr_hot;

  assign set_hot = temp_code >= CODE_W'(TEMP_HOT);
  assign clr_hot = temp_code <= CODE_W'(TEMP_COOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hot <= 1'b0;
    else if (set_hot) hot <= 1'b1;
    else if (clr_hot) hot <= 1'b0;
  end

  AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    hot && !clr_hot |=> hot); // R9

endmodule

// File: rtl/sup_blank_gen.sv
module sup_blank_gen #(
  parameter int unsigned LEB_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_on,
  output logic blank
);
  localparam int unsigned BW = psu_sup_pkg::cnt_bits(LEB_CYC);
  localparam logic [BW-1:0] LEB_TOP = BW'(LEB_CYC);

  logic [BW-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= '0;
    else if (!gate_on)        age_q <= '0;
    else if (age_q != LEB_TOP) age_q <= age_q + 1'b1;
  end

  assign blank = gate_on && (age_q < LEB_TOP);

  AST_BLANK_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on && !$past(gate_on) |-> blank); // R10

endmodule

// File: rtl/psu_fault_supervisor.sv
module psu_fault_supervisor
  import psu_sup_pkg::*;
#(
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned TON_W     = 8,
  parameter int unsigned VCC_START = 240,
  parameter int unsigned VCC_STOP  = 160,
  parameter int unsigned VCC_OVP   = 480,
  parameter int unsigned FB_OLP    = 240,
  parameter int unsigned FB_OSP    = 160,
  parameter int unsigned SNS_AOCP  = 100,
  parameter int unsigned SNS_ILIM  = 50,
  parameter int unsigned TEMP_HOT  = 137,
  parameter int unsigned TEMP_COOL = 77,
  parameter int unsigned OLP_DLY   = 40,
  parameter int unsigned OSP_DLY   = 25,
  parameter int unsigned TON_SHORT = 50,
  parameter int unsigned LEB_CYC   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vcc_code,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] temp_code,
  input  logic [CODE_W-1:0] sense_code,
  input  logic              gate_on,
  input  logic [TON_W-1:0]  ton_count,
  input  logic              ton_valid,
  output logic              startup_en,
  output logic              switch_en,
  output logic              cl_off,
  output logic              fault_latched,
  output logic [2:0]        fault_code
);

  sup_state_e  state_q;
  fault_code_e code_q;
  fault_code_e code_new;

  // Named comparator events
  logic vcc_ge_start, vcc_lt_stop, vcc_over;
  logic fb_olp, fb_osp, sns_aocp, sns_ilim;
  logic running, short_ton_q, blank, hot;
  logic evt_aocp, evt_ovp, evt_osp, evt_tsd, evt_olp, any_evt;

  assign vcc_ge_start = vcc_code >= CODE_W'(VCC_START);
  assign vcc_lt_stop  = vcc_code <  CODE_W'(VCC_STOP);
  assign vcc_over     = vcc_code >  CODE_W'(VCC_OVP);
  assign fb_olp       = fb_code  >  CODE_W'(FB_OLP);
  assign fb_osp       = fb_code  >  CODE_W'(FB_OSP);
  assign sns_aocp     = sense_code > CODE_W'(SNS_AOCP);
  assign sns_ilim     = sense_code > CODE_W'(SNS_ILIM);
  assign running      = (state_q == ST_RUN);

  // Short-pulse flag from the last on-time report
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         short_ton_q <= 1'b0;
    else if (!running)  short_ton_q <= 1'b0;
    else if (ton_valid) short_ton_q <= ton_count < TON_W'(TON_SHORT);
  end

  sup_persist_timer #(.LIMIT(OLP_DLY)) u_olp_tmr (
    .clk(clk), .rst_n(rst_n), .arm(running), .cond(fb_olp), .fire(evt_olp));

  sup_persist_timer #(.LIMIT(OSP_DLY)) u_osp_tmr (
    .clk(clk), .rst_n(rst_n), .arm(running), .cond(fb_osp && short_ton_q),
    .fire(evt_osp));

  sup_thermal_hyst #(.CODE_W(CODE_W), .TEMP_HOT(TEMP_HOT), .TEMP_COOL(TEMP_COOL))
    u_therm (.clk(clk), .rst_n(rst_n), .temp_code(temp_code), .hot(hot));

  sup_blank_gen #(.LEB_CYC(LEB_CYC)) u_leb (
    .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .blank(blank));

  assign evt_aocp = running && gate_on && sns_aocp;
  assign evt_ovp  = running && vcc_over;
  assign evt_tsd  = running && hot;
  assign any_evt  = evt_aocp || evt_ovp || evt_osp || evt_tsd || evt_olp;
  assign code_new = pick_first(evt_aocp, evt_ovp, evt_osp, evt_tsd, evt_olp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CHARGE;
      code_q  <= FC_NONE;
    end else begin
      case (state_q)
        ST_CHARGE: if (vcc_ge_start) state_q <= ST_RUN;
        ST_RUN: begin
          if (any_evt) begin
            state_q <= ST_FAULT;
            code_q  <= code_new;
          end else if (vcc_lt_stop) begin
            state_q <= ST_CHARGE;
          end
        end
        ST_FAULT: if (vcc_lt_stop) begin
          state_q <= ST_CHARGE;
          code_q  <= FC_NONE;
        end
        default: state_q <= ST_CHARGE;
      endcase
    end
  end

  assign startup_en    = (state_q == ST_CHARGE);
  assign switch_en     = running;
  assign fault_latched = (state_q == ST_FAULT);
  assign fault_code    = code_q;
  assign cl_off        = running && gate_on && !blank && sns_ilim;

  AST_START_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(switch_en) |-> $past(vcc_ge_start)); // R2
  AST_UVLO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    switch_en && vcc_lt_stop && !any_evt |=> startup_en); // R3
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched && !vcc_lt_stop |=> fault_latched && !switch_en && !startup_en); // R4
  AST_OVP_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    switch_en && vcc_over |=> fault_latched); // R5
  AST_AOCP_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    switch_en && gate_on && sns_aocp |=> fault_latched && fault_code == 3'd1); // R8
  AST_CUT_NOT_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on && !$past(gate_on) |-> !cl_off); // R10
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched && $past(fault_latched) |-> $stable(fault_code)); // R11

endmodule

// File: tb/sim_psu_fault_supervisor.sv
module sim_psu_fault_supervisor;

  localparam int LEB = 15, OLPD = 40, OSPD = 25;
  localparam logic [5:0] CHG = 6'b100_000, RUN = 6'b010_000;

  typedef struct packed {
    logic [9:0] vcc;
    logic [9:0] fb;
    logic [9:0] temp;
    logic [9:0] sense;
    logic       gate;
    logic [7:0] cyc;
    logic [5:0] exp;   // {startup_en, switch_en, fault_latched, fault_code}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{10'd100, 10'd50, 10'd25, 10'd0, 1'b0, 8'd3, CHG, 4'd2},        // R2 below start
    '{10'd239, 10'd50, 10'd25, 10'd0, 1'b0, 8'd2, CHG, 4'd2},        // R2 one below
    '{10'd240, 10'd50, 10'd25, 10'd0, 1'b0, 8'd1, RUN, 4'd2},        // R2 at start
    '{10'd200, 10'd50, 10'd25, 10'd0, 1'b0, 8'd5, RUN, 4'd3},        // R3 hysteresis
    '{10'd159, 10'd50, 10'd25, 10'd0, 1'b0, 8'd1, CHG, 4'd3},        // R3 stop
    '{10'd200, 10'd50, 10'd25, 10'd0, 1'b0, 8'd2, CHG, 4'd3},        // R3 no restart
    '{10'd250, 10'd50, 10'd25, 10'd0, 1'b0, 8'd1, RUN, 4'd2},
    '{10'd481, 10'd50, 10'd25, 10'd0, 1'b0, 8'd1, 6'b001_010, 4'd5}, // R5
    '{10'd300, 10'd50, 10'd25, 10'd0, 1'b0, 8'd3, 6'b001_010, 4'd4}, // R4 held
    '{10'd159, 10'd50, 10'd25, 10'd0, 1'b0, 8'd1, CHG, 4'd4},        // R4 clear
    '{10'd245, 10'd50, 10'd25, 10'd0, 1'b0, 8'd1, RUN, 4'd4},        // R4 restart
    '{10'd245, 10'd50, 10'd25, 10'd101, 1'b1, 8'd1, 6'b001_001, 4'd8}, // R8 in blanking
    '{10'd150, 10'd50, 10'd25, 10'd0, 1'b0, 8'd1, CHG, 4'd4},
    '{10'd260, 10'd50, 10'd25, 10'd0, 1'b0, 8'd1, RUN, 4'd2},
    '{10'd260, 10'd50, 10'd137, 10'd0, 1'b0, 8'd1, RUN, 4'd9},       // R9 flag first
    '{10'd260, 10'd50, 10'd137, 10'd0, 1'b0, 8'd1, 6'b001_100, 4'd9},// R9 trip
    '{10'd150, 10'd50, 10'd100, 10'd0, 1'b0, 8'd1, CHG, 4'd9},
    '{10'd260, 10'd50, 10'd100, 10'd0, 1'b0, 8'd2, 6'b001_100, 4'd9},// R9 still hot
    '{10'd150, 10'd50, 10'd77, 10'd0, 1'b0, 8'd1, CHG, 4'd9},        // R9 cooled
    '{10'd260, 10'd50, 10'd77, 10'd0, 1'b0, 8'd3, RUN, 4'd9}         // R9 runs
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] vcc = '0, fb = '0, temp = 10'd25, sense = '0;
  logic gate = 1'b0, tvalid = 1'b0;
  logic [7:0] tcount = '0;
  logic st_en, sw_en, cut, flt;
  logic [2:0] code;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  psu_fault_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .vcc_code(vcc), .fb_code(fb), .temp_code(temp),
    .sense_code(sense), .gate_on(gate), .ton_count(tcount), .ton_valid(tvalid),
    .startup_en(st_en), .switch_en(sw_en), .cl_off(cut),
    .fault_latched(flt), .fault_code(code));

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [5:0] exp);
    check(req, {st_en, sw_en, flt, code}, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1 reset", CHG);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vcc = TBL[i].vcc; fb = TBL[i].fb; temp = TBL[i].temp;
      sense = TBL[i].sense; gate = TBL[i].gate;
      step(int'(TBL[i].cyc));
      check($sformatf("R%0d row %0d", TBL[i].req, i), {st_en, sw_en, flt, code}, TBL[i].exp);
    end
    temp = 10'd25;

    // R10 blanking of the current-limit cutoff
    gate = 1'b1; sense = 10'd60;
    step(LEB - 1);
    check("R10 blanked", {5'b0, cut}, 6'd0);
    step(1);
    check("R10 after blank", {5'b0, cut}, 6'd1);
    gate = 1'b0; sense = 10'd0;
    step(1);
    check("R10 gate off", {5'b0, cut}, 6'd0);

    // R7 long pulse does not arm the short detector
    tvalid = 1'b1; tcount = 8'd50; step(1); tvalid = 1'b0;
    fb = 10'd161; step(OSPD + 5);
    check_state("R7 long pulse", RUN);
    fb = 10'd100;
    tvalid = 1'b1; tcount = 8'd49; step(1); tvalid = 1'b0;
    fb = 10'd161; step(OSPD - 1);
    check_state("R7 before delay", RUN);
    step(1);
    check_state("R7 short trip", 6'b001_011);
    fb = 10'd100; vcc = 10'd150; step(1);
    vcc = 10'd260; step(1);
    check_state("R4 restart", RUN);

    // R6 overload delay and count restart
    fb = 10'd241; step(OLPD - 1);
    check_state("R6 before delay", RUN);
    fb = 10'd100; step(1);
    fb = 10'd241; step(OLPD - 1);
    check_state("R6 count restarted", RUN);
    step(1);
    check_state("R6 overload trip", 6'b001_101);
    fb = 10'd100; vcc = 10'd150; step(1);
    vcc = 10'd260; step(1);

    // R11 simultaneous faults, lowest code kept
    vcc = 10'd481; gate = 1'b1; sense = 10'd101; step(1);
    check_state("R11 priority", 6'b001_001);
    vcc = 10'd300; gate = 1'b0; sense = 10'd0; step(3);
    check_state("R11 code held", 6'b001_001);
    vcc = 10'd150; step(1);
    vcc = 10'd260; step(1);

    // R4 undervoltage and overcurrent on the same edge
    vcc = 10'd159; gate = 1'b1; sense = 10'd101; step(1);
    check_state("R4 fault wins", 6'b001_001);
    gate = 1'b0; sense = 10'd0; step(1);
    check_state("R4 then clears", CHG);

    // R1 reset while running
    vcc = 10'd260; step(1);
    rst_n = 1'b0; step(1);
    check_state("R1 reset from run", CHG);
    rst_n = 1'b1;

    finish_run();
  end

endmodule